// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and decides, once per instruction, whether the core must leave its program and enter a service routine. It watches five hardware request lines. One is a non-maskable trap. Three are maskable lines, called A, B and C here, and each has a fixed service address. The fifth is a general request that carries no vector. For the general request the block raises an acknowledge strobe, and the requesting device then supplies the address itself. The core pulses `sampleStb` at the single point of each instruction where pending requests may be examined. The block resolves priority on that cycle and, one clock later, reports the decision as a one-cycle `irqTake` pulse together with a service address or an acknowledge.

A global enable flag and per-line mask bits gate the maskable and general lines. Accepting any hardware request clears the global enable. The core's enable command re-arms it, and the enable takes effect only after the next instruction boundary. A small decoder maps software restart opcodes to their fixed vectors, and no mask or enable applies to it. Saving and restoring the program counter is left to the core.

Top module: `pvic_top`

## Requirements
- R1: After reset the global enable is 0, all three mask bits are 1 (masked), line A's pending latch is clear and `irqTake`, `intAck`, `irqVectored` and `irqVector` are 0.
- R2: Requests are evaluated only in a cycle with `sampleStb`=1. `irqTake` is high for exactly the one cycle after such a cycle and is never high otherwise.
- R3: When several requests are acceptable at once, the winner follows the order trap > A > B > C > general. The vectors are trap 0x0024, A 0x003C, B 0x0034 and C 0x002C, and `irqVectored`=1 for these four.
- R4: Lines A, B, C and the general line are accepted only when the global enable is 1 and, for A, B and C, the line's mask bit is 0. The trap is accepted regardless of enable and masks.
- R5: A rising edge on `req75` (line A) sets a pending latch even while the line is masked. The latch stays set until line A is accepted or `clr75` is pulsed.
- R6: Lines B (`req65`) and C (`req55`) are level-sensitive. They are evaluated from their level at the sample cycle.
- R7: The trap is accepted only after a rising edge of `trapReq` and only while `trapReq` is still high at the sample cycle. A level held high after its edge has been serviced, or a pulse that drops before sampling, is not accepted.
- R8: Accepting any hardware request clears the global enable. After an `enCmd` pulse, the next sample cycle still sees the enable as 0. Sample cycles after that see it as 1. `disCmd` clears the enable and cancels a pending `enCmd`.
- R9: A `maskWr` pulse loads `maskData[2:0]` as the masks {A,B,C} only when `maskData[3]`=1. Otherwise the masks are unchanged.
- R10: Accepting the general line pulses `intAck` together with `irqTake`, with `irqVectored`=0 and `irqVector`=0.
- R11: `swHit`=1 when `swOpcode` has the form 11nnn111. `swVector` is then n×8, that is 0x0000 to 0x0038. Otherwise `swHit`=0 and `swVector`=0.
- R12: `status` is {A pending, B level, C level, global enable, mask A, mask B, mask C}, with bit 6 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | Instruction-boundary sample point |
| trapReq | input | 1 | Non-maskable trap request |
| req75 | input | 1 | Line A, edge-latched maskable request |
| req65 | input | 1 | Line B, level maskable request |
| req55 | input | 1 | Line C, level maskable request |
| genReq | input | 1 | General non-vectored request |
| maskWr | input | 1 | Mask write strobe |
| maskData | input | 4 | [3] set-enable, [2:0] masks {A,B,C} |
| clr75 | input | 1 | Clear line A pending latch |
| enCmd | input | 1 | Enable command (delayed effect) |
| disCmd | input | 1 | Disable command |
| swOpcode | input | 8 | Opcode for software restart decode |
| swHit | output | 1 | Opcode is a restart |
| swVector | output | 16 | Restart vector |
| irqTake | output | 1 | Interrupt accepted pulse |
| irqVector | output | 16 | Service address of accepted request |
| irqVectored | output | 1 | Accepted request has a fixed vector |
| intAck | output | 1 | Acknowledge for general request |
| status | output | 7 | Readable masks, enable and pending state |

## Verification
The properties assume that `sampleStb` is a single-cycle pulse and that `enCmd`, `disCmd`, `clr75` and `maskWr` never coincide with a sample cycle. They also assume that a request edge is applied at least two clocks before the sample that should see it, since the edge detectors add a register stage. The bench drives every command in its own cycle between sample pulses and holds each request steady from two clocks before the sample until after the result is checked. The bench resets the block between table rows, so every row starts from the known reset state.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int VEC_W = 16;
  localparam int NUM_SRC = 5;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_A    = 3'd2,
    SRC_B    = 3'd3,
    SRC_C    = 3'd4,
    SRC_GEN  = 3'd5
  } srcSel_e;

  typedef struct packed {
    logic    take;
    srcSel_e src;
  } ctrlStrobes_t;

  function automatic logic [VEC_W-1:0] srcVector(srcSel_e s);
    case (s)
      SRC_TRAP: srcVector = 16'h0024;
      SRC_A:    srcVector = 16'h003C;
      SRC_B:    srcVector = 16'h0034;
      SRC_C:    srcVector = 16'h002C;
      default:  srcVector = '0;
    endcase
  endfunction
endpackage

// File: rtl/pvic_ctrl.sv
module pvic_ctrl
  import pvic_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleStb,
  input  logic         trapReq,
  input  logic         req75,
  input  logic         req65,
  input  logic         req55,
  input  logic         genReq,
  input  logic         clr75,
  input  logic         enCmd,
  input  logic         disCmd,
  input  logic [2:0]   maskQ,
  output ctrlStrobes_t strb,
  output logic         ieQ,
  output logic         pend75Q
);
  logic prevTrap, prev75, trapLatch, enArm;
  logic [NUM_SRC-1:0] okVec;
  logic takeA, takeTrap;

  always_comb begin
    okVec[0] = trapLatch & trapReq;
    okVec[1] = pend75Q & ~maskQ[2] & ieQ;
    okVec[2] = req65 & ~maskQ[1] & ieQ;
    okVec[3] = req55 & ~maskQ[0] & ieQ;
    okVec[4] = genReq & ieQ;
  end

  always_comb begin
    strb.take = 1'b0;
    strb.src  = SRC_NONE;
    if (sampleStb) begin
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (okVec[i]) begin
          strb.take = 1'b1;
          strb.src  = srcSel_e'(3'(i + 1));
        end
      end
    end
  end

  assign takeA    = strb.take && (strb.src == SRC_A);
  assign takeTrap = strb.take && (strb.src == SRC_TRAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTrap  <= 1'b0;
      prev75    <= 1'b0;
      trapLatch <= 1'b0;
      pend75Q   <= 1'b0;
    end else begin
      prevTrap <= trapReq;
      prev75   <= req75;
      if (trapReq && !prevTrap)
        trapLatch <= 1'b1;
      else if (!trapReq || takeTrap)
        trapLatch <= 1'b0;
      if (req75 && !prev75)
        pend75Q <= 1'b1;
      else if (clr75 || takeA)
        pend75Q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ   <= 1'b0;
      enArm <= 1'b0;
    end else if (disCmd) begin
      ieQ   <= 1'b0;
      enArm <= 1'b0;
    end else begin
      if (strb.take) begin
        ieQ   <= 1'b0;
        enArm <= 1'b0;
      end else if (sampleStb && enArm) begin
        ieQ   <= 1'b1;
        enArm <= 1'b0;
      end
      if (enCmd)
        enArm <= 1'b1;
    end
  end

  AST_IE_DROPS_ON_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> !ieQ); // R8
  AST_A_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pend75Q && !clr75 && !takeA) |=> pend75Q); // R5
endmodule

// File: rtl/pvic_datapath.sv
module pvic_datapath
  import pvic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic             maskWr,
  input  logic [3:0]       maskData,
  input  logic             ieQ,
  input  logic             pend75Q,
  input  logic             req65,
  input  logic             req55,
  input  logic [7:0]       swOpcode,
  output logic [2:0]       maskQ,
  output logic             swHit,
  output logic [VEC_W-1:0] swVector,
  output logic             irqTake,
  output logic [VEC_W-1:0] irqVector,
  output logic             irqVectored,
  output logic             intAck,
  output logic [6:0]       status
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      maskQ <= 3'b111;
    else if (maskWr && maskData[3])
      maskQ <= maskData[2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqTake     <= 1'b0;
      irqVector   <= '0;
      irqVectored <= 1'b0;
      intAck      <= 1'b0;
    end else begin
      irqTake     <= strb.take;
      irqVector   <= strb.take ? srcVector(strb.src) : '0;
      irqVectored <= strb.take && (strb.src != SRC_GEN);
      intAck      <= strb.take && (strb.src == SRC_GEN);
    end
  end

  always_comb begin
    swHit    = (swOpcode[7:6] == 2'b11) && (swOpcode[2:0] == 3'b111);
    swVector = swHit ? {{(VEC_W-6){1'b0}}, swOpcode[5:3], 3'b000} : '0;
  end

  assign status = {pend75Q, req65, req55, ieQ, maskQ};

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(maskWr && maskData[3]) |=> $stable(maskQ)); // R9
  AST_ACK_UNVECTORED: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> (irqTake && !irqVectored && irqVector == '0)); // R10
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleStb,
  input  logic        trapReq,
  input  logic        req75,
  input  logic        req65,
  input  logic        req55,
  input  logic        genReq,
  input  logic        maskWr,
  input  logic [3:0]  maskData,
  input  logic        clr75,
  input  logic        enCmd,
  input  logic        disCmd,
  input  logic [7:0]  swOpcode,
  output logic        swHit,
  output logic [15:0] swVector,
  output logic        irqTake,
  output logic [15:0] irqVector,
  output logic        irqVectored,
  output logic        intAck,
  output logic [6:0]  status
);
  ctrlStrobes_t strb;
  logic ieQ, pend75Q;
  logic [2:0] maskQ;

  pvic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .trapReq(trapReq),
    .req75(req75), .req65(req65), .req55(req55), .genReq(genReq),
    .clr75(clr75), .enCmd(enCmd), .disCmd(disCmd), .maskQ(maskQ),
    .strb(strb), .ieQ(ieQ), .pend75Q(pend75Q)
  );

  pvic_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .maskWr(maskWr), .maskData(maskData),
    .ieQ(ieQ), .pend75Q(pend75Q), .req65(req65), .req55(req55),
    .swOpcode(swOpcode), .maskQ(maskQ), .swHit(swHit), .swVector(swVector),
    .irqTake(irqTake), .irqVector(irqVector), .irqVectored(irqVectored),
    .intAck(intAck), .status(status)
  );

  AST_TAKE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> $past(sampleStb)); // R2
  AST_TRAP_STILL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (irqTake && irqVector == 16'h0024) |-> $past(trapReq)); // R7
  AST_A_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (irqTake && irqVector == 16'h003C) |-> $past(status[3] && !status[2])); // R4
endmodule

// File: tb/pvic_top_test.sv
module pvic_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 10;

  logic clk = 0, rstN = 0, sampleStb = 0, trapReq = 0, req75 = 0, req65 = 0;
  logic req55 = 0, genReq = 0, maskWr = 0, clr75 = 0, enCmd = 0, disCmd = 0;
  logic [3:0] maskData = 0;
  logic [7:0] swOpcode = 0;
  logic swHit, irqTake, irqVectored, intAck;
  logic [15:0] swVector, irqVector;
  logic [6:0] status;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvic_top uut (.*);

  // row: {trap,a,b,c,gen}[5], masks{A,B,C}[3], enable[1], expTake[1], expVec[16], expAck[1]
  typedef struct packed {
    logic [4:0]  req;
    logic [2:0]  mask;
    logic        en;
    logic        take;
    logic [15:0] vec;
    logic        ack;
  } row_t;

  localparam row_t TABLE [NROWS] = '{
    '{5'b11111, 3'b000, 1'b1, 1'b1, 16'h0024, 1'b0}, // R3 trap wins
    '{5'b01111, 3'b000, 1'b1, 1'b1, 16'h003C, 1'b0}, // R3 A over B
    '{5'b00111, 3'b000, 1'b1, 1'b1, 16'h0034, 1'b0}, // R3 B over C
    '{5'b00011, 3'b000, 1'b1, 1'b1, 16'h002C, 1'b0}, // R3 C over gen
    '{5'b00001, 3'b000, 1'b1, 1'b1, 16'h0000, 1'b1}, // R10 gen ack
    '{5'b00110, 3'b010, 1'b1, 1'b1, 16'h002C, 1'b0}, // R4 B masked
    '{5'b01111, 3'b111, 1'b1, 1'b1, 16'h0000, 1'b1}, // R4 all masked, gen
    '{5'b10000, 3'b111, 1'b0, 1'b1, 16'h0024, 1'b0}, // R4 trap while disabled
    '{5'b00100, 3'b000, 1'b0, 1'b0, 16'h0000, 1'b0}, // R4 disabled refuses B
    '{5'b01100, 3'b011, 1'b1, 1'b1, 16'h003C, 1'b0}  // R6 A unmasked only
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic doReset();
    {trapReq, req75, req65, req55, genReq, maskWr, clr75, enCmd, disCmd, sampleStb} = '0;
    rstN = 0; tick(2); rstN = 1; tick(1);
  endtask

  task automatic doSample();
    sampleStb = 1; tick(1); sampleStb = 0;
  endtask

  task automatic writeMask(logic [3:0] d);
    maskData = d; maskWr = 1; tick(1); maskWr = 0;
  endtask

  task automatic enable();
    enCmd = 1; tick(1); enCmd = 0; tick(1);
    doSample(); tick(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    check("R1 status", status, 7'b000_0111);
    check("R1 outputs", {irqTake, intAck, irqVectored, irqVector}, 0);

    foreach (TABLE[i]) begin
      doReset();
      writeMask({1'b1, TABLE[i].mask});
      if (TABLE[i].en) enable();
      {trapReq, req75, req65, req55, genReq} = TABLE[i].req;
      tick(2);
      doSample();
      check($sformatf("R3 row%0d take", i), irqTake, TABLE[i].take);
      check($sformatf("R3 row%0d vec", i), irqVector, TABLE[i].vec);
      check($sformatf("R10 row%0d ack", i), intAck, TABLE[i].ack);
      tick(1);
      check($sformatf("R2 row%0d one-cycle", i), irqTake, 0);
    end

    // R2: no decision without a sample pulse
    doReset(); writeMask(4'b1000); enable();
    req55 = 1; tick(5);
    check("R2 no sample no take", irqTake, 0);
    doSample();
    check("R2 sample take", {irqTake, irqVector}, {1'b1, 16'h002C});
    tick(1);
    // R8: enable cleared, delayed re-enable
    check("R8 ie cleared", status[3], 0);
    doSample();
    check("R8 disabled no take", irqTake, 0);
    enCmd = 1; tick(1); enCmd = 0; tick(1);
    doSample();
    check("R8 enable not yet", irqTake, 0);
    tick(1); doSample();
    check("R8 enable effective", {irqTake, irqVector}, {1'b1, 16'h002C});
    tick(1);
    // R8: disCmd cancels arming
    req55 = 0;
    enCmd = 1; tick(1); enCmd = 0; disCmd = 1; tick(1); disCmd = 0;
    doSample(); tick(1); req55 = 1; tick(1); doSample();
    check("R8 disable cancels", irqTake, 0);
    req55 = 0;

    // R5: line A edge while masked stays pending
    doReset(); writeMask(4'b1111); enable();
    req75 = 1; tick(1); req75 = 0; tick(2);
    check("R5 pending while masked", status[6], 1);
    doSample();
    check("R5 masked no take", irqTake, 0);
    tick(1);
    writeMask(4'b1011); tick(1);
    doSample();
    check("R5 unmask take", {irqTake, irqVector}, {1'b1, 16'h003C});
    tick(1);
    check("R5 cleared by accept", status[6], 0);
    req75 = 1; tick(1); req75 = 0; tick(1);
    check("R5 set again", status[6], 1);
    clr75 = 1; tick(1); clr75 = 0;
    check("R5 cleared by command", status[6], 0);

    // R9: write without set-enable ignored
    writeMask(4'b0111);
    check("R9 ignored write", status[2:0], 3'b011);
    writeMask(4'b1101);
    check("R9 applied write", status[2:0], 3'b101);

    // R6 / R12 status levels
    req65 = 1; tick(1);
    check("R6 B level visible", status[5], 1);
    req65 = 0; req55 = 1; tick(1);
    check("R12 C level visible", status[6:4], 3'b001);
    req55 = 0;

    // R7: trap edge+level rules
    doReset();
    trapReq = 1; tick(2); doSample();
    check("R7 trap taken", {irqTake, irqVector}, {1'b1, 16'h0024});
    tick(1); doSample();
    check("R7 held level no retake", irqTake, 0);
    trapReq = 0; tick(1);
    trapReq = 1; tick(1); trapReq = 0; tick(2); doSample();
    check("R7 dropped pulse refused", irqTake, 0);

    // R11 software restart decode
    swOpcode = 8'hFF; #1;
    check("R11 rst7", {swHit, swVector}, {1'b1, 16'h0038});
    swOpcode = 8'hC7; #1;
    check("R11 rst0", {swHit, swVector}, {1'b1, 16'h0000});
    swOpcode = 8'hEF; #1;
    check("R11 rst5", {swHit, swVector}, {1'b1, 16'h0028});
    swOpcode = 8'h3E; #1;
    check("R11 non-restart", {swHit, swVector}, {1'b0, 16'h0000});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule